// File: doc/BRIEF.md
# Status-Polled Converter Frame Reader

This block is a host-side SPI master for a delta-sigma converter that signals the end of a conversion on its own data line. On a start command it drops chip select and, after one SCK half-period, samples the converter's data output. A high level means the conversion is still running. The host then raises chip select for a programmable idle gap and polls again. A low level means a result is waiting. The host keeps chip select low and issues 24 SCK pulses. It shifts a configuration word out on its data line, most significant bit first, and shifts the 24-bit result frame in.

The frame is decoded into a status bit, a sign bit and a 17-bit magnitude, and a one-cycle result strobe is raised. The decode also flags a frame error when a bit that must be zero reads as one. A poll budget limits how long the host waits for a conversion. An abort input raises chip select at once, which tells the converter to discard the read and start a new conversion. SCK is derived from the system clock by a parameterised divider and rests low.

Top module: `adc_frame_poller`

## Requirements
- R1: While reset is held and in the first cycle after it, cs_n_o is 1, sck_o and sdi_o are 0, busy_o, done_o, timeout_o and aborted_o are 0, and status_o, sign_o, mag_o and frame_err_o are 0.
- R2: After start_i, each poll drives cs_n_o low and samples sdo_i one SCK half-period later. A sample of 1 raises cs_n_o for exactly idle_cycles_i+1 system clocks before the next poll. A sample of 0 begins the read, so a converter that is busy for N polls is polled N+1 times.
- R3: A read gives exactly 24 SCK pulses. cs_n_o stays low from the ready poll to the end of the 24th pulse, and sck_o is 0 whenever cs_n_o is 1.
- R4: On the rising SCK edges of a read, sdi_o carries cfg_i (captured at start) most significant bit first for the first CFG_BITS edges, and 0 on every later edge.
- R5: The 24-bit frame is taken in order: the ready poll sample is bit 23, and the bits read after SCK falling edges 1 to 23 are bits 22 down to 0. status_o is bit 23, sign_o is bit 21, and mag_o is bits 20 down to 4, with bit 20 as its MSB.
- R6: frame_err_o is 1 when bit 22 or any of bits 3 down to 0 of the frame is 1. It is 0 otherwise.
- R7: done_o pulses for one cycle at the end of the 24th SCK pulse, and cs_n_o is already 1 in that cycle. The decoded outputs change only on done_o and hold through later timeouts and aborts.
- R8: If every poll samples 1, timeout_o pulses once max_polls_i polls have been made, where a value of 0 allows one poll. cs_n_o returns high and done_o is not raised.
- R9: abort_i while busy_o is 1 returns cs_n_o high and sck_o low in the next cycle and pulses aborted_o. done_o is not raised.
- R10: start_i while busy_o is 1 is ignored: the transfer in progress keeps its captured configuration word and its poll sequence.
- R11: Each SCK high phase lasts exactly CLK_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a poll-and-read sequence (used when idle) |
| cfg_i | input | CFG_BITS | Configuration word to send during the read |
| abort_i | input | 1 | End the current sequence at once |
| idle_cycles_i | input | IDLE_W | Chip-select-high gap between polls, minus one |
| max_polls_i | input | POLL_W | Poll budget before timeout |
| sdo_i | input | 1 | Converter data/status output |
| sck_o | output | 1 | Serial clock, rests low |
| cs_n_o | output | 1 | Active-low chip select |
| sdi_o | output | 1 | Serial data to the converter |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle result-valid strobe |
| timeout_o | output | 1 | One-cycle poll-budget-exhausted strobe |
| aborted_o | output | 1 | One-cycle abort acknowledge |
| status_o | output | 1 | Frame bit 23 |
| sign_o | output | 1 | Frame bit 21 |
| mag_o | output | 17 | Frame bits 20 to 4 |
| frame_err_o | output | 1 | A must-be-zero bit read as one |

## Verification
The hardest case to reach is the exact hand-off between the last busy poll and the read. Here the converter's status output changes from 1 to 0 only on a particular falling edge of chip select, and the host must then keep chip select low and start clocking without a gap. The bench models the converter. It counts chip-select falls and reports ready only after a busy count that each table row sets. This walks the sequence through zero, one and several busy polls, and it measures the chip-select-high gap in system clocks. An abort is forced in the middle of a read by watching the model's rising-SCK count, and a poll budget below the busy count brings about the timeout.

// File: rtl/adcpoll_pkg.sv
// Shared frame layout and controller state encoding for the polled reader.
// Assumes a fixed 24-bit frame: status, dummy, sign, 17 result bits, 4 pads.
package adcpoll_pkg;
    localparam int FRAME_BITS = 24;
    localparam int STATUS_POS = 23;
    localparam int DUMMY_POS  = 22;
    localparam int SIGN_POS   = 21;
    localparam int MAG_BITS   = 17;
    localparam int MAG_LSB    = 4;
    localparam int PAD_BITS   = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_POLL = 2'd1,
        ST_GAP  = 2'd2,
        ST_READ = 2'd3
    } poll_state_e;
endpackage

// File: rtl/adcpoll_sck_div.sv
// Half-period tick generator for the serial clock.
// Emits a one-cycle tick every HALF_DIV clocks while en is high; restarts
// its count from zero whenever en is low, so the first tick after enabling
// arrives exactly HALF_DIV clocks later.
module adcpoll_sck_div #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    // Count clocks within one SCK half-period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = en && (cnt == LAST);
endmodule

// File: rtl/adcpoll_unpack.sv
// Combinational decoder of one received 24-bit frame into its fields.
// Assumes the frame is presented MSB-first as received (bit 23 = status).
module adcpoll_unpack
    import adcpoll_pkg::*;
(
    input  logic [FRAME_BITS-1:0] frame,
    output logic                  status,
    output logic                  sign,
    output logic [MAG_BITS-1:0]   mag,
    output logic                  err
);
    // Split the frame and flag must-be-zero bits that read as one.
    always_comb begin
        status = frame[STATUS_POS];
        sign   = frame[SIGN_POS];
        mag    = frame[MAG_LSB +: MAG_BITS];
        err    = frame[DUMMY_POS] | (|frame[PAD_BITS-1:0]);
    end
endmodule

// File: rtl/adc_frame_poller.sv
// Host reader for a converter that reports end of conversion on its data line.
// Polls the status by lowering chip select, waits an idle gap between busy
// polls, then clocks a 24-bit frame in while sending a configuration word.
// Assumes: the converter shifts on SCK falling edges and samples SDI on
// rising edges; CFG_BITS <= 24; sdo_i is already synchronous to clk.
module adc_frame_poller
    import adcpoll_pkg::*;
#(
    parameter int CLK_DIV  = 4,
    parameter int CFG_BITS = 8,
    parameter int IDLE_W   = 8,
    parameter int POLL_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [CFG_BITS-1:0] cfg_i,
    input  logic                abort_i,
    input  logic [IDLE_W-1:0]   idle_cycles_i,
    input  logic [POLL_W-1:0]   max_polls_i,
    input  logic                sdo_i,
    output logic                sck_o,
    output logic                cs_n_o,
    output logic                sdi_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                timeout_o,
    output logic                aborted_o,
    output logic                status_o,
    output logic                sign_o,
    output logic [MAG_BITS-1:0] mag_o,
    output logic                frame_err_o
);
    localparam int BCW = $clog2(FRAME_BITS + 1);
    localparam logic [BCW-1:0] LAST_CLK = BCW'(FRAME_BITS - 1);
    localparam int SHW = FRAME_BITS - 1;

    poll_state_e           state;
    logic [POLL_W-1:0]     poll_cnt;
    logic [IDLE_W-1:0]     gap_cnt;
    logic [BCW-1:0]        clk_cnt;
    logic [CFG_BITS-1:0]   cfg_q;
    logic [CFG_BITS-1:0]   cfg_sh;
    logic [SHW-1:0]        rx_sh;
    logic                  stat_q;
    logic                  sck_q;
    logic                  sdi_q;
    logic                  tick;
    logic                  budget_spent;
    logic                  dec_status, dec_sign, dec_err;
    logic [MAG_BITS-1:0]   dec_mag;

    adcpoll_sck_div #(.HALF_DIV(CLK_DIV)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .en   ((state == ST_POLL) || (state == ST_READ)),
        .tick (tick)
    );

    adcpoll_unpack u_unpack (
        .frame (({stat_q, rx_sh})),
        .status(dec_status),
        .sign  (dec_sign),
        .mag   (dec_mag),
        .err   (dec_err)
    );

    // Decide whether the poll now ending uses up the budget.
    always_comb begin
        budget_spent = ({1'b0, poll_cnt} + 1'b1) >= {1'b0, max_polls_i};
    end

    // Sequence polls, gaps and the frame read; produce strobes and results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            poll_cnt    <= '0;
            gap_cnt     <= '0;
            clk_cnt     <= '0;
            cfg_q       <= '0;
            cfg_sh      <= '0;
            rx_sh       <= '0;
            stat_q      <= 1'b0;
            sck_q       <= 1'b0;
            sdi_q       <= 1'b0;
            done_o      <= 1'b0;
            timeout_o   <= 1'b0;
            aborted_o   <= 1'b0;
            status_o    <= 1'b0;
            sign_o      <= 1'b0;
            mag_o       <= '0;
            frame_err_o <= 1'b0;
        end else begin
            done_o    <= 1'b0;
            timeout_o <= 1'b0;
            aborted_o <= 1'b0;
            if (state != ST_IDLE && abort_i) begin
                state     <= ST_IDLE;
                sck_q     <= 1'b0;
                sdi_q     <= 1'b0;
                aborted_o <= 1'b1;
            end else begin
                case (state)
                    ST_IDLE: begin
                        if (start_i) begin
                            cfg_q    <= cfg_i;
                            poll_cnt <= '0;
                            state    <= ST_POLL;
                        end
                    end
                    ST_POLL: begin
                        if (tick) begin
                            stat_q <= sdo_i;
                            if (!sdo_i) begin
                                state   <= ST_READ;
                                clk_cnt <= '0;
                                sck_q   <= 1'b0;
                                sdi_q   <= cfg_q[CFG_BITS-1];
                                cfg_sh  <= cfg_q << 1;
                            end else if (budget_spent) begin
                                state     <= ST_IDLE;
                                timeout_o <= 1'b1;
                            end else begin
                                poll_cnt <= poll_cnt + 1'b1;
                                gap_cnt  <= '0;
                                state    <= ST_GAP;
                            end
                        end
                    end
                    ST_GAP: begin
                        if (gap_cnt == idle_cycles_i) begin
                            state <= ST_POLL;
                        end else begin
                            gap_cnt <= gap_cnt + 1'b1;
                        end
                    end
                    ST_READ: begin
                        if (tick) begin
                            if (!sck_q) begin
                                if (clk_cnt != '0) begin
                                    rx_sh <= {rx_sh[SHW-2:0], sdo_i};
                                end
                                sck_q <= 1'b1;
                            end else begin
                                sck_q   <= 1'b0;
                                clk_cnt <= clk_cnt + 1'b1;
                                if (clk_cnt == LAST_CLK) begin
                                    state       <= ST_IDLE;
                                    sdi_q       <= 1'b0;
                                    done_o      <= 1'b1;
                                    status_o    <= dec_status;
                                    sign_o      <= dec_sign;
                                    mag_o       <= dec_mag;
                                    frame_err_o <= dec_err;
                                end else begin
                                    sdi_q  <= cfg_sh[CFG_BITS-1];
                                    cfg_sh <= cfg_sh << 1;
                                end
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign sck_o  = sck_q;
    assign sdi_o  = sdi_q;
    assign cs_n_o = !((state == ST_POLL) || (state == ST_READ));
    assign busy_o = (state != ST_IDLE);
endmodule

// File: rtl/adc_frame_poller_chk.sv
// Protocol checker for adc_frame_poller, attached by bind below.
// Watches only the top-level pins and relates them over time.
module adc_frame_poller_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n_o,
    input logic sck_o,
    input logic busy_o,
    input logic done_o,
    input logic timeout_o,
    input logic aborted_o,
    input logic abort_i
);
    // R3
    sck_low_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sck_o);

    // R3
    sck_rise_only_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_o) |-> !cs_n_o);

    // R7
    done_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    done_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cs_n_o && !busy_o));

    // R8
    strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, timeout_o, aborted_o}));

    // R9
    abort_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i && busy_o) |=> (aborted_o && cs_n_o && !sck_o));

    // R1
    idle_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> cs_n_o);
endmodule

bind adc_frame_poller adc_frame_poller_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n_o   (cs_n_o),
    .sck_o    (sck_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .timeout_o(timeout_o),
    .aborted_o(aborted_o),
    .abort_i  (abort_i)
);

// File: tb/adc_frame_poller_bench.sv
// Bench for adc_frame_poller: a behavioural converter model, a vector table
// walked by one loop, then directed reset, timeout, abort and restart cases.
module adc_frame_poller_bench;
    localparam int CLK_DIV  = 4;
    localparam int CFG_BITS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  cfg_i = '0;
    logic        abort_i = 1'b0;
    logic [7:0]  idle_cycles_i = 8'd3;
    logic [7:0]  max_polls_i = 8'd8;
    logic        sdo_i;
    logic        sck_o, cs_n_o, sdi_o, busy_o, done_o, timeout_o, aborted_o;
    logic        status_o, sign_o, frame_err_o;
    logic [16:0] mag_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    adc_frame_poller #(.CLK_DIV(CLK_DIV), .CFG_BITS(CFG_BITS)) u_adc_frame_poller (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_i(cfg_i),
        .abort_i(abort_i), .idle_cycles_i(idle_cycles_i), .max_polls_i(max_polls_i),
        .sdo_i(sdo_i), .sck_o(sck_o), .cs_n_o(cs_n_o), .sdi_o(sdi_o),
        .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o),
        .aborted_o(aborted_o), .status_o(status_o), .sign_o(sign_o),
        .mag_o(mag_o), .frame_err_o(frame_err_o)
    );

    // Converter model: all of its state is written in this one process.
    logic [23:0] m_frame = '0;
    int          m_busy = 0;
    int          base_polls = 0;
    int          m_polls = 0;
    int          m_rises = 0;
    int          m_idx = 0;
    logic        m_ready = 1'b0;
    logic        m_sdo = 1'b1;
    logic [23:0] m_rx = '0;
    logic        prev_cs = 1'b1;
    logic        prev_sck = 1'b0;

    always @(cs_n_o or sck_o) begin
        if (prev_cs === 1'b1 && cs_n_o === 1'b0) begin
            m_polls++;
            m_ready = (m_polls - base_polls) > m_busy;
            m_idx = 23;
            m_sdo = m_ready ? m_frame[23] : 1'b1;
        end else if (prev_cs === 1'b0 && cs_n_o === 1'b1) begin
            m_sdo = 1'b1;
            m_ready = 1'b0;
        end else if (cs_n_o === 1'b0 && prev_sck === 1'b0 && sck_o === 1'b1) begin
            m_rx = {m_rx[22:0], sdi_o};
            m_rises++;
        end else if (cs_n_o === 1'b0 && prev_sck === 1'b1 && sck_o === 1'b0 && m_ready) begin
            m_idx--;
            m_sdo = (m_idx >= 0) ? m_frame[m_idx] : 1'b0;
        end
        prev_cs = cs_n_o;
        prev_sck = sck_o;
    end
    assign sdo_i = m_sdo;

    // Pin monitor: chip-select-high gap length and SCK high-phase length.
    int gap_run = 0, last_gap = 0, hi_run = 0, last_hi = 0;
    always @(negedge clk) begin
        if (busy_o === 1'b1 && cs_n_o === 1'b1) gap_run++;
        else if (gap_run != 0) begin last_gap = gap_run; gap_run = 0; end
        if (sck_o === 1'b1) hi_run++;
        else if (hi_run != 0) begin last_hi = hi_run; hi_run = 0; end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Wait at falling clock edges for one of the end strobes: 1 done, 2 timeout, 3 abort.
    task automatic wait_end(output int kind);
        int n = 0;
        kind = 0;
        while (kind == 0 && n < 20000) begin
            @(negedge clk);
            n++;
            if (done_o) kind = 1;
            else if (timeout_o) kind = 2;
            else if (aborted_o) kind = 3;
        end
    endtask

    task automatic launch(input logic [23:0] frame, input logic [7:0] cfg,
                          input int busy, input logic [7:0] maxp);
        m_frame = {1'b0, frame[22:0]};
        m_busy = busy;
        base_polls = m_polls;
        cfg_i = cfg;
        max_polls_i = maxp;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Table row: frame[35:12], cfg[11:4], busy polls[3:0].
    localparam logic [35:0] VEC [6] = '{
        {24'h3FFFF0, 8'hA5, 4'd0},
        {24'h000000, 8'h00, 4'd2},
        {24'h123450, 8'h3C, 4'd1},
        {24'h400000, 8'hFF, 4'd0},
        {24'h2AAAA1, 8'h81, 4'd3},
        {24'h955550, 8'h5A, 4'd7}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int kind;
        int base_rises;
        logic [23:0] f;
        logic [16:0] held_mag;
        logic held_sign;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(cs_n_o === 1'b1 && sck_o === 1'b0 && sdi_o === 1'b0, "R1", "pins in reset",
            {cs_n_o, sck_o, sdi_o}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy_o, done_o, timeout_o, aborted_o} === 4'b0, "R1", "strobes after reset",
            {busy_o, done_o, timeout_o, aborted_o}, 0);
        chk({status_o, sign_o, mag_o, frame_err_o} === '0, "R1", "results after reset",
            {status_o, sign_o, mag_o, frame_err_o}, 0);

        // Table walk: R2 to R7 and R11
        for (int i = 0; i < 6; i++) begin
            f = {1'b0, VEC[i][34:12]};
            idle_cycles_i = 8'(3 + i);
            base_rises = m_rises;
            launch(VEC[i][35:12], VEC[i][11:4], int'(VEC[i][3:0]), 8'd8);
            wait_end(kind);
            chk(kind == 1, "R7", "end kind", kind, 1);
            chk(cs_n_o === 1'b1, "R7", "cs high at done", cs_n_o, 1);
            chk(mag_o === f[20:4], "R5", "magnitude", mag_o, f[20:4]);
            chk(sign_o === f[21], "R5", "sign", sign_o, f[21]);
            chk(status_o === 1'b0, "R5", "status", status_o, 0);
            chk(frame_err_o === (f[22] | (|f[3:0])), "R6", "frame error",
                frame_err_o, f[22] | (|f[3:0]));
            chk(m_rx === {VEC[i][11:4], 16'h0}, "R4", "bits seen on SDI",
                m_rx, {VEC[i][11:4], 16'h0});
            chk(m_rises - base_rises == 24, "R3", "SCK pulses", m_rises - base_rises, 24);
            chk(m_polls - base_polls == int'(VEC[i][3:0]) + 1, "R2", "poll count",
                m_polls - base_polls, int'(VEC[i][3:0]) + 1);
            if (VEC[i][3:0] != 0)
                chk(last_gap == 4 + i, "R2", "gap length", last_gap, 4 + i);
            chk(last_hi == CLK_DIV, "R11", "SCK high phase", last_hi, CLK_DIV);
            @(negedge clk);
            chk(done_o === 1'b0, "R7", "done one cycle", done_o, 0);
        end

        // R8: timeout after three busy polls, results held
        held_mag = mag_o;
        held_sign = sign_o;
        idle_cycles_i = 8'd2;
        launch(24'h3FFFF0, 8'h77, 100, 8'd3);
        wait_end(kind);
        chk(kind == 2, "R8", "end kind", kind, 2);
        chk(m_polls - base_polls == 3, "R8", "polls before timeout", m_polls - base_polls, 3);
        chk(cs_n_o === 1'b1, "R8", "cs high after timeout", cs_n_o, 1);
        chk(mag_o === held_mag && sign_o === held_sign, "R7", "results held on timeout",
            mag_o, held_mag);

        // R8: budget of zero allows one poll
        launch(24'h3FFFF0, 8'h77, 100, 8'd0);
        wait_end(kind);
        chk(kind == 2 && m_polls - base_polls == 1, "R8", "zero budget polls",
            m_polls - base_polls, 1);

        // R9: abort in the middle of a read
        base_rises = m_rises;
        launch(24'h2FFFF0, 8'h99, 0, 8'd8);
        while (m_rises - base_rises < 5) @(negedge clk);
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        chk(aborted_o === 1'b1 && cs_n_o === 1'b1 && sck_o === 1'b0, "R9", "abort response",
            {aborted_o, cs_n_o, sck_o}, 3'b110);
        repeat (40) @(negedge clk);
        chk(m_rises - base_rises < 24, "R9", "read cut short", m_rises - base_rises, 5);
        chk(mag_o === held_mag && busy_o === 1'b0, "R9", "results held after abort",
            mag_o, held_mag);

        // R10: a second start during a busy sequence is ignored
        idle_cycles_i = 8'd4;
        launch(24'h255550, 8'hC3, 2, 8'd8);
        repeat (3) @(negedge clk);
        cfg_i = 8'h11;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_end(kind);
        chk(kind == 1 && m_rx === 24'hC30000, "R10", "cfg kept", m_rx, 24'hC30000);
        chk(m_polls - base_polls == 3, "R10", "poll sequence kept", m_polls - base_polls, 3);
        chk(mag_o === 17'h05555 && sign_o === 1'b1, "R5", "restart frame", mag_o, 17'h05555);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule